// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a single-port synchronous static memory with a built-in burst address generator and a registered read path. It is meant as the data store of a secondary cache. Address, write data, byte write enables, chip enable and three burst strobes are all taken on the rising clock edge. Two strobes load a new base address: the processor strobe and the controller strobe. The third strobe, advance, moves a 2-bit burst counter on during a burst. The counter forms the low address bits in interleaved order: the low bits of the base are XORed with the count. The burst wraps to its base after four accesses.

Read data goes through an output register, so the word for a read accepted at edge k appears just after edge k+1. The tri-state data bus is modelled as separate `din` and `dout` ports. The output flag `dout_en` stands for the bus being driven. It depends on `oe_n` without a clock. The depth is set by `ADDR_W`. The default of 10 keeps elaboration small, and `ADDR_W = 15` gives the full 32,768 x 18 organisation.

A two-state controller tracks whether a base address is held. **ST_IDLE** means deselected, with no base held. **ST_BURST** means selected, with a base held. The controller has these transitions:
- **T_LOAD** (either state to ST_BURST): a valid processor-strobe start or a controller-strobe start with chip enable low.
- **T_DESELECT** (either state to ST_IDLE): a controller-strobe start with chip enable high.
- **T_STAY**: any continue or suspend cycle, and any processor-strobe start blocked by chip enable high, keeps the current state.

Top module: `bsram_burst`

## Requirements
- R1: After reset the block is in ST_IDLE and `dout_en` is 0. Continue cycles issued before any base load perform no access.
- R2: A read accepted at rising edge k puts the addressed word on `dout` just after edge k+1, with `dout_en` = 1 while `oe_n` = 0.
- R3: `wr_lo_n` = 0 writes bits 8:0 and `wr_hi_n` = 0 writes bits 17:9. Each lane is written on its own, and a lane that is not enabled keeps its old value.
- R4: A controller-strobe start loads the external address as base and clears the count. It needs `strb_ctl_n` = 0, `strb_cpu_n` = 1 and `ce_n` = 0. The access in that cycle is a write if either write enable is 0, otherwise a read.
- R5: A processor-strobe start loads the external address and always reads. It needs `strb_cpu_n` = 0 and `ce_n` = 0. Both write enables and `strb_ctl_n` are ignored in that cycle.
- R6: Chip enable is looked at only on an address load. `strb_ctl_n` = 0 with `ce_n` = 1 moves to ST_IDLE with no access. `strb_cpu_n` = 0 with `ce_n` = 1 does not load, and its address is ignored.
- R7: With both strobes at 1 and `adv_n` = 0 in ST_BURST, the count is incremented before the access. The access address is base[ADDR_W-1:2] followed by base[1:0] XOR count, so a base ending in 11 gives the low-bit order 11, 10, 01, 00.
- R8: With both strobes at 1 and `adv_n` = 1 in ST_BURST, the address of the previous access is used again. This is a wait state.
- R9: The fifth access of a burst, after four advances, returns to the base address.
- R10: A single write may follow a processor-strobe start. In the next cycle both strobes are 1, `adv_n` = 1, a write enable is 0 and `din` is valid, and the word goes to the loaded address.
- R11: `dout_en` is 1 only in the cycle after a read access and only while `oe_n` = 0. It is 0 after write cycles, after deselected cycles and whenever `oe_n` = 1.
- R12: Continue and suspend cycles in ST_IDLE leave the memory unchanged, even with write enables asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | ADDR_W | External word address |
| din | input | DATA_W | Write data |
| wr_lo_n | input | 1 | Active-low write enable, bits 8:0 |
| wr_hi_n | input | 1 | Active-low write enable, bits 17:9 |
| ce_n | input | 1 | Active-low chip enable, used on loads only |
| strb_cpu_n | input | 1 | Active-low processor address strobe (read start) |
| strb_ctl_n | input | 1 | Active-low controller address strobe (read/write start) |
| adv_n | input | 1 | Active-low burst advance |
| oe_n | input | 1 | Active-low output enable, not clocked |
| dout | output | DATA_W | Read data, zero when not driven |
| dout_en | output | 1 | High when the output bus would be driven |

## Verification
The bench reads back a burst whose base ends in 11, so every interleaved step differs from a linear one. A counter that counts up linearly would return the words in the wrong order, and a counter that does not wrap would read a neighbouring word on the fifth access. The processor-strobe start is issued with write enables and the controller strobe asserted together. A design that lets write enables win would overwrite the word instead of returning its old value. Write cycles issued while deselected, and a processor strobe blocked by chip enable, are followed by read-back of the words they would have hit; memory that leaks writes in ST_IDLE shows changed data. Byte-lane writes and the timing of the output enable are checked against the old contents, which catches crossed lanes and a flag that is clocked instead of combinational.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bsram_state_e;

    typedef enum logic [2:0] {
        CYC_CPU_LOAD,
        CYC_CTL_LOAD,
        CYC_DESELECT,
        CYC_STEP,
        CYC_HOLD
    } bsram_cycle_e;

endpackage

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr #(
    parameter int AW = 10,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] ext_addr,
    output logic [AW-1:0] acc_addr
);
    logic [AW-1:0] base_q;
    logic [BW-1:0] cnt_q;
    logic [BW-1:0] cnt_nx;

    always_comb begin
        if (load) begin
            cnt_nx   = '0;
            acc_addr = ext_addr;
        end else begin
            cnt_nx   = cnt_q + BW'(step);
            acc_addr = {base_q[AW-1:BW], base_q[BW-1:0] ^ cnt_nx};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (load) base_q <= ext_addr;
            cnt_q <= cnt_nx;
        end
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int AW = 10,
    parameter int DW = 18,
    parameter int LW = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW/LW-1:0] lane_we,
    input  logic             rd_req,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    output logic             rd_vld
);
    localparam int NL    = DW / LW;
    localparam int DEPTH = 1 << AW;

    logic [AW-1:0] raddr_q;
    logic          req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raddr_q <= '0;
            req_q   <= 1'b0;
            rd_vld  <= 1'b0;
        end else begin
            if (rd_req) raddr_q <= addr;
            req_q  <= rd_req;
            rd_vld <= req_q;
        end
    end

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] mem [DEPTH];
        logic [LW-1:0] q;

        always_ff @(posedge clk) begin
            if (lane_we[g]) mem[addr] <= wdata[g*LW +: LW];
        end

        always_ff @(posedge clk) begin
            q <= mem[raddr_q];
        end

        assign rdata[g*LW +: LW] = q;
    end
endmodule

// File: rtl/bsram_burst.sv
module bsram_burst
    import bsram_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 18,
    parameter int LANE_W  = 9,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_lo_n,
    input  logic              wr_hi_n,
    input  logic              ce_n,
    input  logic              strb_cpu_n,
    input  logic              strb_ctl_n,
    input  logic              adv_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int NUM_LANES = DATA_W / LANE_W;

    bsram_state_e      state_q, state_nx;
    bsram_cycle_e      cyc;
    logic              in_burst;
    logic              we_any;
    logic              acc_rd, acc_wr;
    logic              do_load, do_step;
    logic [ADDR_W-1:0] acc_addr;
    logic [NUM_LANES-1:0] lane_we;
    logic [DATA_W-1:0] rdata;
    logic              rd_vld;

    assign in_burst = (state_q == ST_BURST);
    assign we_any   = !wr_lo_n || !wr_hi_n;

    // cycle classification: processor strobe wins, controller strobe next
    always_comb begin
        if (!strb_cpu_n && !ce_n)
            cyc = CYC_CPU_LOAD;
        else if (!strb_ctl_n)
            cyc = ce_n ? CYC_DESELECT : CYC_CTL_LOAD;
        else
            cyc = adv_n ? CYC_HOLD : CYC_STEP;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // next state and access outputs
    always_comb begin
        state_nx = state_q;
        acc_rd   = 1'b0;
        acc_wr   = 1'b0;
        do_load  = 1'b0;
        do_step  = 1'b0;
        unique case (cyc)
            CYC_CPU_LOAD: begin
                state_nx = ST_BURST;
                do_load  = 1'b1;
                acc_rd   = 1'b1;
            end
            CYC_CTL_LOAD: begin
                state_nx = ST_BURST;
                do_load  = 1'b1;
                acc_wr   = we_any;
                acc_rd   = !we_any;
            end
            CYC_DESELECT: begin
                state_nx = ST_IDLE;
            end
            CYC_STEP, CYC_HOLD: begin
                if (in_burst) begin
                    do_step = (cyc == CYC_STEP);
                    acc_wr  = we_any;
                    acc_rd  = !we_any;
                end
            end
            default: state_nx = state_q;
        endcase
    end

    assign lane_we = {acc_wr && !wr_hi_n, acc_wr && !wr_lo_n};

    bsram_burst_addr #(
        .AW(ADDR_W),
        .BW(BURST_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .step     (do_step),
        .ext_addr (addr),
        .acc_addr (acc_addr)
    );

    bsram_array #(
        .AW(ADDR_W),
        .DW(DATA_W),
        .LW(LANE_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .rd_req  (acc_rd),
        .addr    (acc_addr),
        .wdata   (din),
        .rdata   (rdata),
        .rd_vld  (rd_vld)
    );

    // output gating, not clocked by oe_n
    always_comb begin
        dout_en = rd_vld && !oe_n;
        dout    = dout_en ? rdata : '0;
    end
endmodule

// File: rtl/bsram_burst_chk.sv
module bsram_burst_chk #(
    parameter int AW = 10,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strb_cpu_n,
    input logic          strb_ctl_n,
    input logic          adv_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          dout_en,
    input logic          in_burst,
    input logic          acc_rd,
    input logic          acc_wr,
    input logic          rd_vld,
    input logic [AW-1:0] acc_addr
);
    p_cpu_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu_n && !ce_n) |-> (acc_rd && !acc_wr));

    p_deselect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && ce_n && !(!strb_cpu_n && !ce_n)) |=> !in_burst);

    p_rd_pipe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> ##1 rd_vld);

    p_no_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> ##1 !rd_vld);

    p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_burst && strb_cpu_n && strb_ctl_n) |-> (!acc_rd && !acc_wr));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && strb_cpu_n && strb_ctl_n && adv_n) |-> (acc_addr == $past(acc_addr)));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && strb_cpu_n && strb_ctl_n && !adv_n) |->
            ((acc_addr[AW-1:BW] == $past(acc_addr[AW-1:BW])) &&
             (acc_addr[BW-1:0] != $past(acc_addr[BW-1:0]))));
endmodule

bind bsram_burst bsram_burst_chk #(
    .AW(ADDR_W),
    .BW(BURST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .ce_n       (ce_n),
    .oe_n       (oe_n),
    .dout_en    (dout_en),
    .in_burst   (in_burst),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .rd_vld     (rd_vld),
    .acc_addr   (acc_addr)
);

// File: tb/tb_bsram_burst.sv
module tb_bsram_burst;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic          wr_lo_n, wr_hi_n, ce_n, strb_cpu_n, strb_ctl_n, adv_n, oe_n;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_chk = 0;
    int n_err = 0;
    logic finished = 1'b0;

    localparam logic [DW-1:0] D0 = 18'h0A001;
    localparam logic [DW-1:0] D1 = 18'h15102;
    localparam logic [DW-1:0] D2 = 18'h2A203;
    localparam logic [DW-1:0] D3 = 18'h35304;
    localparam logic [DW-1:0] JUNK = 18'h3FFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsram_burst dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
        .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .ce_n(ce_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
    );

    // one bus cycle: drive at negedge, take the rising edge, return at the next negedge
    task automatic drv(input logic cpu, input logic ctl, input logic adv,
                       input logic ce, input logic wl, input logic wh,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
        strb_cpu_n = cpu; strb_ctl_n = ctl; adv_n = adv; ce_n = ce;
        wr_lo_n = wl; wr_hi_n = wh; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        drv(1, 0, 1, 0, 0, 0, a, d);
    endtask
    task automatic ctl_rd(input logic [AW-1:0] a);
        drv(1, 0, 1, 0, 1, 1, a, '0);
    endtask
    task automatic step_rd();  drv(1, 1, 0, 0, 1, 1, '0, '0); endtask
    task automatic hold_rd();  drv(1, 1, 1, 0, 1, 1, '0, '0); endtask
    task automatic step_wr(input logic [DW-1:0] d); drv(1, 1, 0, 0, 0, 0, '0, d); endtask
    task automatic desel();    drv(1, 0, 1, 1, 1, 1, '0, '0); endtask

    task automatic chk(input string req, input logic en_exp, input logic [DW-1:0] d_exp);
        n_chk++;
        if (dout_en !== en_exp || (en_exp && dout !== d_exp)) begin
            n_err++;
            $display("FAIL %s: dout_en=%0b dout=%h expected dout_en=%0b dout=%h",
                     req, dout_en, dout, en_exp, d_exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; oe_n = 1'b0;
        strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1; ce_n = 1;
        wr_lo_n = 1; wr_hi_n = 1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset", 0, '0);
        hold_rd();                       // continue while deselected: nothing
        step_rd();
        chk("R1 no access before load", 0, '0);
    endtask

    task automatic t_burst();
        // write burst from base 0x041: addresses 041, 040, 043, 042
        ctl_wr(10'h041, D0);
        step_wr(D1);
        step_wr(D2);
        step_wr(D3);
        // read burst from base 0x043: 043, 042, 041, 040, wrap 043
        ctl_rd(10'h043);
        step_rd(); chk("R4 R2 ctl read base 043", 1, D2);
        step_rd(); chk("R7 interleave 042", 1, D3);
        step_rd(); chk("R7 interleave 041", 1, D0);
        step_rd(); chk("R7 interleave 040", 1, D1);
        hold_rd(); chk("R9 wrap to base 043", 1, D2);
        hold_rd(); chk("R8 suspend keeps 043", 1, D2);
        step_rd(); chk("R8 second suspend keeps 043", 1, D2);
        desel();   chk("R8 advance after suspend 042", 1, D3);
        desel();   chk("R11 deselected no output", 0, '0);
    endtask

    task automatic t_oe();
        oe_n = 1'b1;
        ctl_rd(10'h041);
        desel(); chk("R11 oe high blanks output", 0, '0);
        oe_n = 1'b0;
        #1; chk("R11 oe low drives without clock", 1, D0);
        desel();
    endtask

    task automatic t_deselect();
        ctl_rd(10'h041);
        desel(); chk("R6 read before deselect", 1, D0);
        step_wr(JUNK); chk("R6 deselect performs no access", 0, '0);
        hold_rd();     chk("R12 continue while deselected", 0, '0);
        drv(0, 1, 1, 1, 1, 1, 10'h041, '0); chk("R12 idle hold no output", 0, '0);
        desel();       chk("R6 blocked cpu strobe no read", 0, '0);
        ctl_rd(10'h041);
        step_rd(); chk("R12 word 041 unchanged", 1, D0);
        desel();   chk("R12 word 040 unchanged", 1, D1);
        desel();
    endtask

    task automatic t_cpu();
        logic [DW-1:0] v1, v2, v3;
        v1 = 18'h01234; v2 = 18'h0ABCD; v3 = 18'h2BCDE;
        ctl_wr(10'h200, v1);
        ctl_wr(10'h201, v3);
        // cpu start with write enables and controller strobe asserted
        drv(0, 0, 1, 0, 0, 0, 10'h201, JUNK);
        desel(); chk("R5 cpu start reads old data", 1, v3);
        desel();
        ctl_rd(10'h201);
        desel(); chk("R5 cpu start wrote nothing", 1, v3);
        // cpu start then single write
        drv(0, 1, 1, 0, 0, 0, 10'h200, JUNK);
        drv(1, 1, 1, 0, 0, 0, 10'h3FF, v2); chk("R5 cpu start read before write", 1, v1);
        desel(); chk("R11 write cycle not driven", 0, '0);
        ctl_rd(10'h200);
        desel(); chk("R10 single write landed", 1, v2);
        desel();
    endtask

    task automatic t_bytes();
        logic [DW-1:0] hd, exp;
        hd = 18'h2A955;
        ctl_wr(10'h301, JUNK);
        drv(1, 0, 1, 0, 0, 1, 10'h301, 18'h00000);
        ctl_rd(10'h301);
        desel(); chk("R3 low lane only", 1, 18'h3FE00);
        drv(1, 0, 1, 0, 1, 0, 10'h301, hd);
        exp = {hd[17:9], 9'h000};
        ctl_rd(10'h301);
        desel(); chk("R3 high lane only", 1, exp);
        desel();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_burst();
        t_oe();
        t_deselect();
        t_cpu();
        t_bytes();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule